// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral transfer-request lines and the channels of a DMA engine. Every request line owns an 8-bit map entry, written and read over a 32-bit register bus, which says whether the line is routed and to which channel. Request lines are sampled on the clock. A change of level on a routed line is then passed to its channel. The block keeps one request-active bit per channel, which follows the level of the routed request that last changed.

Two event pulses come out of each channel. The request-after-stop pulse fires when a request rises on a channel that had no active request. The end-of-receive pulse fires when a request falls on a channel whose request was active. Both pulses last one cycle. When several routed lines of one channel change in the same cycle, the line with the highest index decides the outcome.

The map entries sit in two separate address windows. Three status words read as zero and discard writes. A write that enables routing to a channel the instance does not have raises an error pulse. The entry is still stored, and a line routed to that channel has no effect on any channel.

Top module: `dreq_chan_map`

## Requirements
- R1: After reset, every map entry reads back 0, and `chan_active`, `ras_pulse`, `eor_pulse` and `map_err` are all 0.
- R2: A map entry stores bits 7:0 of the written word. Bit 7 is the route-enable flag and bits 4:0 are the target channel. A read returns the stored byte in bits 7:0 with bits 31:8 at zero.
- R3: Entry n for n below 64 sits at byte address 0x100 + 4·n. Entry n for n from 64 to NUM_REQ−1 sits at byte address 0x1100 + 4·(n−64).
- R4: Addresses 0xE0, 0xE4 and 0xE8 always read 0, and writes to them change no map entry.
- R5: A request line whose entry has bit 7 clear has no effect on any channel output.
- R6: A routed line that rises while its channel is inactive sets that channel's `chan_active`. It also gives a one-cycle `ras_pulse` for that channel. Both appear at the second rising clock edge after the line changes.
- R7: A routed line that falls while its channel is active clears `chan_active` and gives a one-cycle `eor_pulse` for that channel, with the same two-edge latency.
- R8: A routed rise on an already active channel gives no pulse and keeps the channel active. A routed fall on an inactive channel gives no pulse and keeps it inactive.
- R9: When several routed lines of one channel change in the same cycle, only the line with the highest index is acted on.
- R10: A bus write to an entry address with bit 7 set and bits 4:0 at or above NUM_CH raises `map_err` for one cycle after the write edge and still stores the byte. A line routed to such a channel affects no channel output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| dreq | input | NUM_REQ | Peripheral request lines |
| chan_active | output | NUM_CH | Per-channel request-active state |
| ras_pulse | output | NUM_CH | Request rose on an idle channel |
| eor_pulse | output | NUM_CH | Request fell on an active channel |
| map_err | output | 1 | Write routed to a nonexistent channel |

## Verification
The assertions check several rules on every cycle. The two pulses are never both high on one channel. A request-after-stop pulse always goes with an active bit that has just risen, and an end-of-receive pulse with one that has just fallen. No active bit changes without one of these pulses. The error pulse only follows a write, and the status words read zero. Other behaviour needs the bench's scenarios, because it depends on which line is routed where. That covers the two address windows, the highest index winning within a channel, routes that are disabled or out of range, and the exact two-edge latency.

// File: rtl/dreq_chan_map.sv
module dreq_chan_map #(
  parameter int NUM_REQ  = 75,
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 16,
  parameter int LO_BASE  = 'h0100,
  parameter int HI_BASE  = 'h1100,
  parameter int LO_SPAN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_REQ-1:0] dreq,
  output logic [NUM_CH-1:0] chan_active,
  output logic [NUM_CH-1:0] ras_pulse,
  output logic [NUM_CH-1:0] eor_pulse,
  output logic              map_err
);

  localparam int REQ_W   = $clog2(NUM_REQ);
  localparam int HI_SPAN = NUM_REQ - LO_SPAN;
  localparam logic [ADDR_W-1:0] LO_B   = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_B   = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] LO_LEN = ADDR_W'(4 * LO_SPAN);
  localparam logic [ADDR_W-1:0] HI_LEN = ADDR_W'(4 * HI_SPAN);

  logic [7:0]         map_q [NUM_REQ];
  logic [NUM_REQ-1:0] samp_q, prev_q, chg;
  logic [ADDR_W-1:0]  lo_off, hi_off;
  logic               lo_hit, hi_hit, map_hit;
  logic [REQ_W-1:0]   sel_idx;

  assign lo_off  = reg_addr - LO_B;
  assign hi_off  = reg_addr - HI_B;
  assign lo_hit  = (lo_off < LO_LEN) && (reg_addr[1:0] == 2'b00);
  assign hi_hit  = (hi_off < HI_LEN) && (reg_addr[1:0] == 2'b00);
  assign map_hit = lo_hit | hi_hit;
  assign sel_idx = lo_hit ? REQ_W'(lo_off[ADDR_W-1:2])
                          : REQ_W'(hi_off[ADDR_W-1:2]) + REQ_W'(LO_SPAN);

  assign reg_rdata = map_hit ? {24'h0, map_q[sel_idx]} : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REQ; i++) map_q[i] <= 8'h00;
      map_err <= 1'b0;
    end else begin
      if (reg_we && map_hit) map_q[sel_idx] <= reg_wdata[7:0];
      map_err <= reg_we && map_hit && reg_wdata[7] &&
                 ({1'b0, reg_wdata[4:0]} >= 6'(NUM_CH));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= dreq;
      prev_q <= samp_q;
    end
  end

  assign chg = samp_q ^ prev_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, lvl;

    always_comb begin
      hit = 1'b0;
      lvl = 1'b0;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (chg[i] && map_q[i][7] && (map_q[i][4:0] == 5'(c))) begin
          hit = 1'b1;
          lvl = samp_q[i];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chan_active[c] <= 1'b0;
        ras_pulse[c]   <= 1'b0;
        eor_pulse[c]   <= 1'b0;
      end else if (hit) begin
        ras_pulse[c]   <= lvl & ~chan_active[c];
        eor_pulse[c]   <= ~lvl & chan_active[c];
        chan_active[c] <= lvl;
      end else begin
        ras_pulse[c]   <= 1'b0;
        eor_pulse[c]   <= 1'b0;
      end
    end
  end

endmodule

module dreq_chan_map_chk #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [NUM_CH-1:0] chan_active,
  input logic [NUM_CH-1:0] ras_pulse,
  input logic [NUM_CH-1:0] eor_pulse,
  input logic              map_err
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & eor_pulse) == '0); // R8

  AST_RAS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & ~(chan_active & ~$past(chan_active))) == '0); // R6

  AST_EOR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse & ~(~chan_active & $past(chan_active))) == '0); // R7

  AST_ACT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_active ^ $past(chan_active)) == (ras_pulse | eor_pulse)); // R8

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> $past(reg_we)); // R10

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'('hE0) || reg_addr == ADDR_W'('hE4) ||
     reg_addr == ADDR_W'('hE8)) |-> reg_rdata == 32'h0); // R4

  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:8] == 24'h0); // R2

endmodule

bind dreq_chan_map dreq_chan_map_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .chan_active(chan_active), .ras_pulse(ras_pulse),
  .eor_pulse(eor_pulse), .map_err(map_err)
);

// File: tb/sim_dreq_chan_map.sv
module sim_dreq_chan_map;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [15:0]       reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NREQ-1:0]   dreq = '0;
  logic [NCH-1:0]    chan_active, ras_pulse, eor_pulse;
  logic              map_err;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dreq_chan_map #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .chan_active(chan_active), .ras_pulse(ras_pulse), .eor_pulse(eor_pulse),
    .map_err(map_err)
  );

  // {req[31:24], level[23:16], chan[15:8], act[2], ras[1], eor[0]}
  localparam logic [31:0] VEC [8] = '{
    32'h03_01_02_06, 32'h46_01_02_04, 32'h03_00_02_01, 32'h46_00_02_00,
    32'h0A_01_05_06, 32'h0A_00_05_01, 32'h46_01_02_06, 32'h46_00_02_01
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] ent_addr(input int n);
    return (n < 64) ? 16'(16'h0100 + 4 * n) : 16'(16'h1100 + 4 * (n - 64));
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle;
    @(posedge clk); @(posedge clk); #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 active", 32'(chan_active), 0);
    chk("R1 ras", 32'(ras_pulse), 0);
    chk("R1 eor", 32'(eor_pulse), 0);
    chk("R1 err", 32'(map_err), 0);
    rd(ent_addr(74), d); chk("R1 entry74", d, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field storage
    wr(ent_addr(5), 32'hFFFF_FF85);
    chk("R2 no err", 32'(map_err), 0);
    rd(ent_addr(5), d); chk("R2 readback", d, 32'h85);
    wr(ent_addr(5), 0);

    // R3 windows
    wr(16'h1128, 32'h8C); rd(ent_addr(74), d); chk("R3 entry74", d, 32'h8C);
    wr(16'h01FC, 32'h0B); rd(ent_addr(63), d); chk("R3 entry63", d, 32'h0B);
    wr(16'h1128, 0); wr(16'h01FC, 0);

    // R4 status words
    wr(ent_addr(0), 32'h81);
    wr(16'h00E0, 32'hFFFF_FFFF); wr(16'h00E4, 32'h0000_0000); wr(16'h00E8, 32'h0000_00FF);
    rd(16'h00E0, d); chk("R4 stat0", d, 0);
    rd(16'h00E8, d); chk("R4 stat2", d, 0);
    rd(ent_addr(0), d); chk("R4 entry0 kept", d, 32'h81);
    wr(ent_addr(0), 0);

    // table: routes req3,req70 -> ch2, req10 -> ch5
    wr(ent_addr(3), 32'h82); wr(ent_addr(70), 32'h82); wr(ent_addr(10), 32'h85);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VEC[i];
      @(negedge clk);
      dreq[v[31:24]] = v[16];
      settle();
      chk($sformatf("R6/R7/R8 vec%0d active", i), 32'(chan_active), 32'(v[2]) << v[15:8]);
      chk($sformatf("R6/R7/R8 vec%0d ras", i), 32'(ras_pulse), 32'(v[1]) << v[15:8]);
      chk($sformatf("R6/R7/R8 vec%0d eor", i), 32'(eor_pulse), 32'(v[0]) << v[15:8]);
    end
    @(posedge clk); #2;
    chk("R6 pulse one cycle", 32'(ras_pulse | eor_pulse), 0);

    // R5 unrouted line
    wr(ent_addr(20), 32'h02);
    @(negedge clk); dreq[20] = 1'b1; settle();
    chk("R5 no active", 32'(chan_active), 0);
    chk("R5 no ras", 32'(ras_pulse), 0);
    @(negedge clk); dreq[20] = 1'b0; settle();

    // R9 highest index wins
    @(negedge clk); dreq[3] = 1'b1; settle();
    @(negedge clk); dreq[3] = 1'b0; dreq[70] = 1'b1; settle();
    chk("R9 high wins active", 32'(chan_active), 32'h4);
    chk("R9 high wins no eor", 32'(eor_pulse), 0);
    @(negedge clk); dreq[3] = 1'b1; dreq[70] = 1'b0; settle();
    chk("R9 high fall active", 32'(chan_active), 0);
    chk("R9 high fall eor", 32'(eor_pulse), 32'h4);
    @(negedge clk); dreq[3] = 1'b0; settle();

    // R10 out-of-range channel
    wr(ent_addr(30), 32'h91);
    chk("R10 err", 32'(map_err), 1);
    @(posedge clk); #2;
    chk("R10 err one cycle", 32'(map_err), 0);
    rd(ent_addr(30), d); chk("R10 stored", d, 32'h91);
    @(negedge clk); dreq[30] = 1'b1; settle();
    chk("R10 no active", 32'(chan_active), 0);
    chk("R10 no ras", 32'(ras_pulse), 0);
    @(negedge clk); dreq[30] = 1'b0; settle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule